// File: doc/BRIEF.md
# Time base and decrementer unit

This block keeps time for a processor core. It holds a 64-bit main time base and a 64-bit alternate time base, which both step by one on a common tick enable. It also holds two 32-bit down-counters, a general decrementer and a hypervisor decrementer, which step down on the same tick. A small register port lets software read and write each 32-bit half of both time bases and the full value of each down-counter. The tick rate comes from outside the block, and so does the way an interrupt is taken inside the core.

Each down-counter has a sticky interrupt flag. The flag is set when the counter steps past zero and wraps to all ones. It is also set when software writes a value with bit 31 set while the counter's own bit 31 is clear. The flag stays set until a one-cycle acknowledge pulse clears it. An external run input freezes both time bases in place without losing their values. A legacy clock mode masks the low word of the main time base. Reading a low word captures the matching high word, so that a later high-word read belongs to the same instant.

Top module: `tb_dec_unit`

## Requirements
- R1: After reset both time bases read zero, both down-counters read 0xFFFFFFFF, every shadow word is zero and both interrupt outputs are low.
- R2: On each cycle with `tick` and `tb_run` high, the main and the alternate time base each go up by one, with the carry running from bit 31 into bit 32.
- R3: While `tb_run` is low, both time bases keep their values, whatever `tick` does. Once `tb_run` returns high they count on from those held values.
- R4: A write to a low word (address 0 or 2) replaces bits 31:0 of that time base and keeps its bits 63:32. A write to a high word (address 1 or 3) replaces bits 63:32 and keeps bits 31:0. A write takes precedence over a tick in the same cycle.
- R5: Writes to the main time base leave the alternate time base unchanged, and writes to the alternate one leave the main one unchanged.
- R6: A read of a low word (address 0 or 2, `rd_en` high) stores bits 63:32 of the same time base, as they stood in that cycle, into that base's shadow word. A read of the high word (address 1 or 3) returns that shadow word. `rdata` is combinational and is zero when `rd_en` is low.
- R7: The decrementer (address 4) goes down by one on every `tick`, whatever `tb_run` is. A write takes precedence over a tick in the same cycle.
- R8: A tick on a decrementer that holds zero loads 0xFFFFFFFF and sets `dec_irq` at the next clock edge.
- R9: A write to the decrementer with `wdata[31]`=1, while the present value has bit 31 = 0, sets `dec_irq`. Any other write leaves the flag to its acknowledge.
- R10: `dec_irq` stays high until a cycle with `dec_ack` high clears it. If a new set cause arrives in the same cycle as the acknowledge, the set wins.
- R11: The hypervisor decrementer (address 5) follows R7 to R10 on its own, with `hdec_irq` and `hdec_ack`.
- R12: While `rtc_mode` is high, reads and writes of the main time base's low word (address 0) are masked with 0x3FFFFF80. The alternate time base is never masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable, one step per cycle |
| tb_run | input | 1 | Time base enable; low freezes both time bases |
| rtc_mode | input | 1 | Legacy clock view of the main low word |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select: 0 main low, 1 main high, 2 alt low, 3 alt high, 4 decrementer, 5 hypervisor decrementer |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| dec_ack | input | 1 | Clears the decrementer interrupt |
| hdec_ack | input | 1 | Clears the hypervisor decrementer interrupt |
| dec_irq | output | 1 | Decrementer interrupt pending |
| hdec_irq | output | 1 | Hypervisor decrementer interrupt pending |

## Verification
The hardest case to reach from the ports is a down-counter hitting zero. From reset this takes four billion ticks, and with random write data it almost never happens. The stimulus therefore writes small values into both counters often, so that both zero crossings occur many times. Some of them fall in the same cycle as an acknowledge or a competing write. Directed steps also place a carry across bit 31 of a time base, and they write the sign bit while the counter holds values of either sign.

// File: rtl/tb_dec_unit.sv
module tb_dec_unit #(
  parameter int DW = 32,
  parameter int AW = 3,
  parameter logic [31:0] RTC_MASK = 32'h3FFFFF80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          tb_run,
  input  logic          rtc_mode,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          dec_ack,
  input  logic          hdec_ack,
  output logic          dec_irq,
  output logic          hdec_irq
);
  localparam int TBW = 2 * DW;
  localparam int NDEC = 2;
  localparam logic [AW-1:0] A_TBL  = AW'(0);
  localparam logic [AW-1:0] A_TBH  = AW'(1);
  localparam logic [AW-1:0] A_ATBL = AW'(2);
  localparam logic [AW-1:0] A_ATBH = AW'(3);
  localparam logic [AW-1:0] A_DEC  = AW'(4);
  localparam logic [AW-1:0] A_HDEC = AW'(5);

  logic [TBW-1:0] tb_q, atb_q;
  logic [DW-1:0]  tb_sh, atb_sh;
  logic [NDEC-1:0][DW-1:0] dcnt;
  logic [NDEC-1:0] irq_q, dset, dwr, dack;

  wire step_tb = tb_run && tick;
  wire [DW-1:0] tbl_wval = rtc_mode ? (wdata & RTC_MASK) : wdata;

  assign dwr  = {wr_en && addr == A_HDEC, wr_en && addr == A_DEC};
  assign dack = {hdec_ack, dec_ack};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
    end else if (wr_en && addr == A_TBL) begin
      tb_q[DW-1:0] <= tbl_wval;
    end else if (wr_en && addr == A_TBH) begin
      tb_q[TBW-1:DW] <= wdata;
    end else if (step_tb) begin
      tb_q <= tb_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atb_q <= '0;
    end else if (wr_en && addr == A_ATBL) begin
      atb_q[DW-1:0] <= wdata;
    end else if (wr_en && addr == A_ATBH) begin
      atb_q[TBW-1:DW] <= wdata;
    end else if (step_tb) begin
      atb_q <= atb_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_sh  <= '0;
      atb_sh <= '0;
    end else if (rd_en) begin
      if (addr == A_TBL)  tb_sh  <= tb_q[TBW-1:DW];
      if (addr == A_ATBL) atb_sh <= atb_q[TBW-1:DW];
    end
  end

  always_comb begin
    for (int i = 0; i < NDEC; i++) begin
      if (dwr[i]) dset[i] = wdata[DW-1] && !dcnt[i][DW-1];
      else        dset[i] = tick && dcnt[i] == '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt  <= '1;
      irq_q <= '0;
    end else begin
      for (int i = 0; i < NDEC; i++) begin
        if (dwr[i])    dcnt[i] <= wdata;
        else if (tick) dcnt[i] <= dcnt[i] - 1'b1;
      end
      irq_q <= dset | (irq_q & ~dack);
    end
  end

  assign dec_irq  = irq_q[0];
  assign hdec_irq = irq_q[1];

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_TBL:   rdata = rtc_mode ? (tb_q[DW-1:0] & RTC_MASK) : tb_q[DW-1:0];
        A_TBH:   rdata = tb_sh;
        A_ATBL:  rdata = atb_q[DW-1:0];
        A_ATBH:  rdata = atb_sh;
        A_DEC:   rdata = dcnt[0];
        A_HDEC:  rdata = dcnt[1];
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tb_dec_unit_chk.sv
module tb_dec_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 tb_run,
  input logic                 wr_en,
  input logic [AW-1:0]        addr,
  input logic                 dec_ack,
  input logic                 hdec_ack,
  input logic [2*DW-1:0]      tb_q,
  input logic [2*DW-1:0]      atb_q,
  input logic [1:0][DW-1:0]   dcnt,
  input logic                 dec_irq,
  input logic                 hdec_irq
);
  wire wr_tb  = wr_en && (addr == AW'(0) || addr == AW'(1));
  wire wr_atb = wr_en && (addr == AW'(2) || addr == AW'(3));
  wire wr_d0  = wr_en && addr == AW'(4);
  wire wr_d1  = wr_en && addr == AW'(5);

  p_tb_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_run && tick && !wr_tb) |=> tb_q == $past(tb_q) + 1'b1);

  p_tb_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tb_run && !wr_tb && !wr_atb) |=> ($stable(tb_q) && $stable(atb_q)));

  p_dec_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_d0 && dcnt[0] != '0) |=> dcnt[0] == $past(dcnt[0]) - 1'b1);

  p_dec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_d0 && dcnt[0] == '0) |=> (dcnt[0] == '1 && dec_irq));

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_irq && !dec_ack) |=> dec_irq);

  p_hdec_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_d1 && dcnt[1] == '0) |=> (dcnt[1] == '1 && hdec_irq));

  p_hirq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hdec_irq && !hdec_ack) |=> hdec_irq);
endmodule

bind tb_dec_unit tb_dec_unit_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tb_run(tb_run), .wr_en(wr_en),
  .addr(addr), .dec_ack(dec_ack), .hdec_ack(hdec_ack), .tb_q(tb_q),
  .atb_q(atb_q), .dcnt(dcnt), .dec_irq(dec_irq), .hdec_irq(hdec_irq)
);

// File: tb/tb_dec_unit_tb.sv
module tb_dec_unit_tb;
  localparam logic [31:0] MASK = 32'h3FFFFF80;

  logic clk = 0, rst_n = 0, tick = 0, tb_run = 0, rtc_mode = 0;
  logic wr_en = 0, rd_en = 0, dec_ack = 0, hdec_ack = 0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic dec_irq, hdec_irq;

  always #2 clk = ~clk;

  tb_dec_unit u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tb_run(tb_run), .rtc_mode(rtc_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .dec_ack(dec_ack), .hdec_ack(hdec_ack), .dec_irq(dec_irq), .hdec_irq(hdec_irq)
  );

  int nchk = 0, nfail = 0;
  logic [63:0] m_tb = '0, m_atb = '0;
  logic [31:0] m_sh = '0, m_ash = '0;
  logic [31:0] m_dec [2] = '{32'hFFFFFFFF, 32'hFFFFFFFF};
  logic m_irq [2] = '{1'b0, 1'b0};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(logic [2:0] a);
    case (a)
      3'd0: return rtc_mode ? (m_tb[31:0] & MASK) : m_tb[31:0];
      3'd1: return m_sh;
      3'd2: return m_atb[31:0];
      3'd3: return m_ash;
      3'd4: return m_dec[0];
      3'd5: return m_dec[1];
      default: return '0;
    endcase
  endfunction

  function automatic string reqof(logic [2:0] a);
    case (a)
      3'd0: return rtc_mode ? "R12" : "R2";
      3'd1, 3'd3: return "R6";
      3'd2: return "R5";
      3'd4: return "R7";
      default: return "R11";
    endcase
  endfunction

  task automatic step(bit t, bit run, bit we, bit re, logic [2:0] a,
                      logic [31:0] wd, bit k0, bit k1);
    bit set;
    tick = t; tb_run = run; wr_en = we; rd_en = re; addr = a; wdata = wd;
    dec_ack = k0; hdec_ack = k1;
    #1;
    if (re) chk(reqof(a), rdata, mread(a));
    chk("R10", 32'(dec_irq), 32'(m_irq[0]));
    chk("R11", 32'(hdec_irq), 32'(m_irq[1]));
    @(posedge clk);
    if (re && a == 3'd0) m_sh = m_tb[63:32];
    if (re && a == 3'd2) m_ash = m_atb[63:32];
    if (we && a == 3'd0) m_tb[31:0] = rtc_mode ? (wd & MASK) : wd;
    else if (we && a == 3'd1) m_tb[63:32] = wd;
    else if (run && t) m_tb = m_tb + 1;
    if (we && a == 3'd2) m_atb[31:0] = wd;
    else if (we && a == 3'd3) m_atb[63:32] = wd;
    else if (run && t) m_atb = m_atb + 1;
    for (int i = 0; i < 2; i++) begin
      set = 0;
      if (we && a == 3'(4 + i)) begin
        set = wd[31] && !m_dec[i][31];
        m_dec[i] = wd;
      end else if (t) begin
        set = (m_dec[i] == 0);
        m_dec[i] = m_dec[i] - 1;
      end
      m_irq[i] = set || (m_irq[i] && !(i == 0 ? k0 : k1));
    end
    @(negedge clk);
  endtask

  task automatic rd(logic [2:0] a);
    step(0, 1, 0, 1, a, 0, 0, 0);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    step(0, 1, 1, 0, a, d, 0, 0);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [2:0] a;
    logic [31:0] d;
    void'($urandom(32'h5EED1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1: reset values on every address
    for (int i = 0; i < 6; i++) rd(3'(i));
    // R2: counting, then the carry across bit 31 (R4 write keeps high word)
    repeat (5) step(1, 1, 0, 0, 0, 0, 0, 0);
    rd(0); rd(1);
    wr(0, 32'hFFFFFFFE);
    repeat (3) step(1, 1, 0, 0, 0, 0, 0, 0);
    rd(0); rd(1);
    wr(1, 32'h12345678); rd(0); rd(1);
    step(1, 1, 1, 0, 0, 32'h00000010, 0, 0); rd(0);
    // R3: freeze and resume
    repeat (6) step(1, 0, 0, 0, 0, 0, 0, 0);
    rd(0); rd(2);
    repeat (2) step(1, 1, 0, 0, 0, 0, 0, 0);
    rd(0); rd(2);
    // R5: alternate base untouched by main writes
    wr(3, 32'hCAFE0001); wr(2, 32'h00000007); wr(1, 32'h0);
    rd(2); rd(3); rd(0); rd(1);
    // R8: wrap through zero
    wr(4, 32'd2);
    repeat (3) step(1, 1, 0, 0, 0, 0, 0, 0);
    rd(4);
    step(0, 1, 0, 0, 0, 0, 1, 0);
    // R10: set beats acknowledge in the same cycle
    wr(4, 32'd0);
    step(1, 1, 0, 0, 0, 0, 1, 0);
    step(0, 1, 0, 0, 0, 0, 1, 0);
    // R9: sign write on positive value sets, on negative value does not
    wr(4, 32'h00000100); wr(4, 32'h80000000);
    step(0, 1, 0, 0, 0, 0, 1, 0);
    wr(4, 32'h90000000); rd(4);
    // R11: hypervisor counter on its own
    wr(5, 32'd1);
    repeat (2) step(1, 1, 0, 0, 0, 0, 0, 0);
    rd(5);
    step(0, 1, 0, 0, 0, 0, 0, 1);
    // R12: legacy clock mask on the main low word
    rtc_mode = 1;
    wr(0, 32'hFFFFFFFF); rd(0); wr(2, 32'hFFFFFFFF); rd(2);
    repeat (3) step(1, 1, 0, 0, 0, 0, 0, 0);
    rd(0);
    rtc_mode = 0; rd(0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      if (($urandom % 50) == 0) rtc_mode = ~rtc_mode;
      a = 3'($urandom % 6);
      d = $urandom;
      if (a >= 3'd4 && ($urandom % 2)) d = $urandom % 6;
      if (a == 3'd0 && ($urandom % 4) == 0) d = 32'hFFFFFFF0 | ($urandom % 16);
      step(($urandom % 4) != 0, ($urandom % 5) != 0, ($urandom % 4) == 0,
           ($urandom % 2) == 0, a, d, ($urandom % 8) == 0, ($urandom % 8) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule